// File: doc/BRIEF.md
# Pipelined Bus Transaction Phase Tracker

This block follows memory-bus transactions as they advance through five ordered phases: request, error report, snoop, response and data. Each phase owns its own signal group on the bus. Each phase therefore holds at most one transaction, and up to five different transactions can occupy the five phases in the same cycle. New transactions enter in order through a valid/ready issue port. Each one carries a tag.

Request, error report and snoop each last one cycle unless the next phase is still occupied. The response phase lasts until the slave raises `rspDone`. A transaction whose response has finished joins an ordered waiting pool. It leaves the pool when the data bus becomes free. The data phase lasts until the data source flags its last beat with `dataLast`. `dataBusy` is high through every data cycle except that final beat. The next data phase starts in the cycle after the final beat.

At most `MAX_OUT` transactions are outstanding at once. At that limit the full flag is raised and further issue attempts are refused. Transactions retire in issue order. Each retirement is shown as a one-cycle pulse that carries the retiring transaction's tag.

Top module: `busPhaseTracker`

## Requirements
- R1: After reset no phase is occupied, `full`, `dataBusy` and `retireValid` are low, and `issueReady` is high.
- R2: A transaction that meets no stall occupies request, error report, snoop, response and data in five consecutive cycles (`phaseValid` bits 0, 1, 2, 3 and 4 in that order), starting in the cycle after it is accepted. Its retire pulse follows in the next cycle.
- R3: Each phase holds at most one transaction, and the transactions in different phases in the same cycle are distinct.
- R4: A transaction is accepted at a clock edge where `issueValid` and `issueReady` are both high. `issueReady` is low while the request phase is occupied and its occupant cannot advance.
- R5: `full` is high exactly while `MAX_OUT` (default 8) transactions are outstanding. While `full` is high, `issueReady` is low and issue attempts are ignored.
- R6: The response phase holds its transaction until `rspDone` is sampled high. Earlier phases stall behind it in order and never overtake it.
- R7: The data phase holds its transaction until `dataLast` is sampled high. `dataBusy` is high in every data-phase cycle except the one in which `dataLast` is high.
- R8: The oldest waiting transaction starts its data phase in the cycle after the previous data phase's last beat. If none is waiting, it starts in the cycle after its response completes.
- R9: Transactions retire in issue order. `retireValid` pulses for one cycle, in the cycle after the last data beat, with `retireTag` equal to the retiring transaction's tag.
- R10: When nothing stalls, an empty slot between two transactions keeps its position as both move through the phases.
- R11: `rspDone` has no effect while the response phase is empty, and `dataLast` has no effect while no data phase is active.
- R12: `rspTag` and `dataTag` show the tags of the transactions currently in the response and data phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | A new transaction is offered |
| issueTag | input | TAG_W | Tag of the offered transaction |
| issueReady | output | 1 | The offered transaction is accepted at this edge |
| full | output | 1 | MAX_OUT transactions are outstanding |
| rspDone | input | 1 | The slave ends the current response phase |
| dataLast | input | 1 | The current data beat is the last one |
| phaseValid | output | 5 | Occupancy: bit0 request, bit1 error report, bit2 snoop, bit3 response, bit4 data |
| dataBusy | output | 1 | A data phase is active and more beats follow |
| rspTag | output | TAG_W | Tag in the response phase |
| dataTag | output | TAG_W | Tag in the data phase |
| retireValid | output | 1 | One-cycle retirement pulse |
| retireTag | output | TAG_W | Tag of the retired transaction |

## Verification
The hardest state to reach from the ports is the outstanding limit. The five phases alone hold only five transactions, so reaching the limit needs several transactions parked in the waiting pool behind a long data phase. The stimulus reaches it with one-cycle responses, ten-beat data phases and issue held high, so the pool fills up and `full` asserts. The issue attempts that follow must then be refused.

Expected phase entry cycles come from an arithmetic recurrence over response length, data length and issue gaps. The bench compares the predicted occupancy, tags and retire cycles with the outputs in every cycle. While a phase is empty, the slave models toggle `rspDone` and `dataLast`.

// File: rtl/busPhasePkg.sv
`timescale 1ns/1ps
package busPhasePkg;
  localparam int PH_REQ = 0;
  localparam int PH_ERR = 1;
  localparam int PH_SNP = 2;
  localparam int PH_RSP = 3;
  localparam int PH_DAT = 4;
  localparam int NUM_PHASES = 5;
  localparam int NUM_STAGES = 4;  // phases before data that move as a shift chain

  typedef struct packed {
    logic push;  // a transaction is accepted
    logic pop;   // the oldest transaction retires
  } tagStrobe_t;
endpackage

// File: rtl/busPhaseCtrl.sv
`timescale 1ns/1ps
module busPhaseCtrl
  import busPhasePkg::*;
#(
  parameter int MAX_OUT = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic issueValid,
  input  logic rspDone,
  input  logic dataLast,
  output logic issueReady,
  output logic full,
  output logic dataBusy,
  output logic [NUM_PHASES-1:0] phaseValid,
  output logic [$clog2(MAX_OUT)-1:0] rspOffset,
  output tagStrobe_t strobe
);
  localparam int CNT_W = $clog2(MAX_OUT + 1);
  localparam int PTR_W = $clog2(MAX_OUT);

  logic [NUM_STAGES-1:0] stageV, stageMove;
  logic dataAct;
  logic [CNT_W-1:0] pendCnt, outCnt;
  logic rspMove, dataFree, dataStart, retireNow, accept;
  logic pendInc, pendDec;

  // Each stage advances when the next one is empty or emptying in this cycle.
  always_comb begin
    stageMove[PH_RSP] = stageV[PH_RSP] && rspDone;
    for (int k = NUM_STAGES - 2; k >= 0; k--) begin
      stageMove[k] = stageV[k] && (!stageV[k+1] || stageMove[k+1]);
    end
  end

  assign rspMove   = stageMove[PH_RSP];
  assign dataFree  = !dataAct || dataLast;
  assign dataStart = dataFree && ((pendCnt != '0) || rspMove);
  assign retireNow = dataAct && dataLast;
  assign full      = (outCnt == CNT_W'(MAX_OUT));
  assign issueReady = !full && (!stageV[PH_REQ] || stageMove[PH_REQ]);
  assign accept    = issueValid && issueReady;
  assign pendInc   = rspMove && !(dataStart && (pendCnt == '0));
  assign pendDec   = dataStart && (pendCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageV  <= '0;
      dataAct <= 1'b0;
      pendCnt <= '0;
      outCnt  <= '0;
    end else begin
      for (int k = 0; k < NUM_STAGES; k++) begin
        if (k == 0) stageV[k] <= accept || (stageV[k] && !stageMove[k]);
        else        stageV[k] <= stageMove[k-1] || (stageV[k] && !stageMove[k]);
      end
      dataAct <= dataStart || (dataAct && !retireNow);
      pendCnt <= pendCnt + CNT_W'(pendInc) - CNT_W'(pendDec);
      outCnt  <= outCnt + CNT_W'(accept) - CNT_W'(retireNow);
    end
  end

  assign phaseValid  = {dataAct, stageV};
  assign dataBusy    = dataAct && !dataLast;
  assign rspOffset   = PTR_W'(pendCnt) + PTR_W'(dataAct);
  assign strobe.push = accept;
  assign strobe.pop  = retireNow;
endmodule

// File: rtl/busPhaseTags.sv
`timescale 1ns/1ps
module busPhaseTags
  import busPhasePkg::*;
#(
  parameter int TAG_W   = 4,
  parameter int MAX_OUT = 8
) (
  input  logic clk,
  input  logic rstN,
  input  tagStrobe_t strobe,
  input  logic [TAG_W-1:0] issueTag,
  input  logic [$clog2(MAX_OUT)-1:0] rspOffset,
  output logic [TAG_W-1:0] rspTag,
  output logic [TAG_W-1:0] dataTag,
  output logic retireValid,
  output logic [TAG_W-1:0] retireTag
);
  localparam int PTR_W = $clog2(MAX_OUT);
  localparam int DEPTH = 1 << PTR_W;

  logic [TAG_W-1:0] tagMem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr, rspIdx;

  always_ff @(posedge clk) begin
    if (strobe.push) tagMem[wrPtr] <= issueTag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr       <= '0;
      rdPtr       <= '0;
      retireValid <= 1'b0;
      retireTag   <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + 1'b1;
      if (strobe.pop) begin
        rdPtr     <= rdPtr + 1'b1;
        retireTag <= tagMem[rdPtr];
      end
      retireValid <= strobe.pop;
    end
  end

  // The oldest outstanding transaction is always the one in (or next for) data.
  assign rspIdx  = rdPtr + rspOffset;
  assign dataTag = tagMem[rdPtr];
  assign rspTag  = tagMem[rspIdx];
endmodule

// File: rtl/busPhaseTracker.sv
`timescale 1ns/1ps
module busPhaseTracker
  import busPhasePkg::*;
#(
  parameter int TAG_W   = 4,
  parameter int MAX_OUT = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic issueValid,
  input  logic [TAG_W-1:0] issueTag,
  output logic issueReady,
  output logic full,
  input  logic rspDone,
  input  logic dataLast,
  output logic [4:0] phaseValid,
  output logic dataBusy,
  output logic [TAG_W-1:0] rspTag,
  output logic [TAG_W-1:0] dataTag,
  output logic retireValid,
  output logic [TAG_W-1:0] retireTag
);
  localparam int PTR_W = $clog2(MAX_OUT);

  tagStrobe_t strobe;
  logic [PTR_W-1:0] rspOffset;

  busPhaseCtrl #(.MAX_OUT(MAX_OUT)) uCtrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .rspDone(rspDone),
    .dataLast(dataLast), .issueReady(issueReady), .full(full),
    .dataBusy(dataBusy), .phaseValid(phaseValid), .rspOffset(rspOffset),
    .strobe(strobe)
  );

  busPhaseTags #(.TAG_W(TAG_W), .MAX_OUT(MAX_OUT)) uTags (
    .clk(clk), .rstN(rstN), .strobe(strobe), .issueTag(issueTag),
    .rspOffset(rspOffset), .rspTag(rspTag), .dataTag(dataTag),
    .retireValid(retireValid), .retireTag(retireTag)
  );
endmodule

// File: rtl/busPhaseTrackerChk.sv
`timescale 1ns/1ps
module busPhaseTrackerChk #(
  parameter int TAG_W = 4
) (
  input logic clk,
  input logic rstN,
  input logic issueValid,
  input logic issueReady,
  input logic full,
  input logic rspDone,
  input logic dataLast,
  input logic [4:0] phaseValid,
  input logic [TAG_W-1:0] rspTag,
  input logic [TAG_W-1:0] dataTag,
  input logic retireValid
);
  assert_accept_enters_R4: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueReady) |=> phaseValid[0]);

  assert_full_refuses_R5: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !issueReady);

  assert_rsp_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (phaseValid[3] && !rspDone) |=> (phaseValid[3] && $stable(rspTag)));

  assert_data_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (phaseValid[4] && !dataLast) |=> (phaseValid[4] && $stable(dataTag)));

  assert_retire_after_last_R9: assert property (@(posedge clk) disable iff (!rstN)
    retireValid |-> $past(phaseValid[4] && dataLast));

  assert_no_phantom_retire_R11: assert property (@(posedge clk) disable iff (!rstN)
    !phaseValid[4] |=> !retireValid);
endmodule

bind busPhaseTracker busPhaseTrackerChk #(.TAG_W(TAG_W)) uChk (
  .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueReady(issueReady),
  .full(full), .rspDone(rspDone), .dataLast(dataLast), .phaseValid(phaseValid),
  .rspTag(rspTag), .dataTag(dataTag), .retireValid(retireValid)
);

// File: tb/sim_busPhaseTracker.sv
`timescale 1ns/1ps
module sim_busPhaseTracker;
  localparam int TAG_W = 4;
  localparam int MAX_OUT = 8;
  localparam int NTX = 12;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issueValid = 1'b0;
  logic [TAG_W-1:0] issueTag = '0;
  logic rspDone = 1'b0;
  logic dataLast = 1'b0;
  logic issueReady, full, dataBusy, retireValid;
  logic [4:0] phaseValid;
  logic [TAG_W-1:0] rspTag, dataTag, retireTag;

  int cyc = 0;
  int nTests = 0;
  int nFails = 0;
  bit finished = 1'b0;

  int e0[NTX], e1[NTX], e2[NTX], e3[NTX], xr[NTX], dd[NTX];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  busPhaseTracker #(.TAG_W(TAG_W), .MAX_OUT(MAX_OUT)) u0 (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueTag(issueTag),
    .issueReady(issueReady), .full(full), .rspDone(rspDone), .dataLast(dataLast),
    .phaseValid(phaseValid), .dataBusy(dataBusy), .rspTag(rspTag), .dataTag(dataTag),
    .retireValid(retireValid), .retireTag(retireTag)
  );

  task automatic check(string req, int act, int exp, string what);
    nTests++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  function automatic int maxi(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [TAG_W-1:0] tagOf(int base, int i);
    return TAG_W'(base + i);
  endfunction

  // Phase entry cycles from the ordering rules: a phase is entered once the
  // previous occupant of that phase leaves, the pool drains in order, and
  // issue waits while MAX_OUT are outstanding.
  task automatic predict(int c0, int R, int L, bit gap);
    for (int i = 0; i < NTX; i++) begin
      if (i == 0) e0[i] = c0 + 1;
      else begin
        e0[i] = e1[i-1];
        if (gap && i == 1) e0[i] = maxi(e0[i], e0[0] + 2);
        if (i >= MAX_OUT) e0[i] = maxi(e0[i], dd[i-MAX_OUT] + L + 1);
      end
      e1[i] = maxi(e0[i] + 1, (i > 0) ? e2[i-1] : 0);
      e2[i] = maxi(e1[i] + 1, (i > 0) ? e3[i-1] : 0);
      e3[i] = maxi(e2[i] + 1, (i > 0) ? xr[i-1] : 0);
      xr[i] = e3[i] + R;
      dd[i] = maxi(xr[i], (i > 0) ? dd[i-1] + L : 0);
    end
  endtask

  task automatic runCase(int R, int L, bit gap, int base);
    int c0, c, idx, rspAge, dataAge, retired, endC, outst;
    bit hold, accFlag, pRv, pDv, expRet, reqOcc, reqLeaves;
    logic [TAG_W-1:0] pRt, pDt, expRt, expDt, expRetTag;
    logic [4:0] expPv;
    bit expBusy;
    @(negedge clk);
    c0 = cyc;
    predict(c0, R, L, gap);
    idx = 0; hold = 0; accFlag = 0; rspAge = 0; dataAge = 0; retired = 0;
    pRv = 0; pDv = 0; pRt = '0; pDt = '0;
    endC = dd[NTX-1] + L + 2;
    while (cyc <= endC) begin
      c = cyc;
      if (accFlag) begin
        idx++;
        if (gap && idx == 1) hold = 1;
      end
      // Slave for the response phase; toggles rspDone while empty (R11).
      if (phaseValid[3]) begin
        rspAge = (pRv && rspTag == pRt) ? rspAge + 1 : 1;
        rspDone = (rspAge >= R);
      end else rspDone = (c % 2) == 1;
      pRv = phaseValid[3]; pRt = rspTag;
      // Data source; toggles dataLast while no data phase (R11).
      if (phaseValid[4]) begin
        dataAge = (pDv && dataTag == pDt) ? dataAge + 1 : 1;
        dataLast = (dataAge >= L);
      end else dataLast = ((c / 2) % 2) == 1;
      pDv = phaseValid[4]; pDt = dataTag;
      issueValid = (idx < NTX) && !hold;
      issueTag = tagOf(base, idx);
      hold = 0;
      #1;
      expPv = '0; expBusy = 0; expRet = 0; outst = 0; reqOcc = 0; reqLeaves = 0;
      expRt = '0; expDt = '0; expRetTag = '0;
      for (int i = 0; i < NTX; i++) begin
        if (e0[i] <= c && c < e1[i]) begin
          expPv[0] = 1; reqOcc = 1; reqLeaves = (e1[i] == c + 1);
        end
        if (e1[i] <= c && c < e2[i]) expPv[1] = 1;
        if (e2[i] <= c && c < e3[i]) expPv[2] = 1;
        if (e3[i] <= c && c < xr[i]) begin expPv[3] = 1; expRt = tagOf(base, i); end
        if (dd[i] <= c && c < dd[i] + L) begin
          expPv[4] = 1; expDt = tagOf(base, i);
          if (c < dd[i] + L - 1) expBusy = 1;
        end
        if (e0[i] <= c && dd[i] + L > c) outst++;
        if (dd[i] + L == c) begin expRet = 1; expRetTag = tagOf(base, i); end
      end
      check("R3 R6 R10", int'(phaseValid), int'(expPv), "phase occupancy");
      check("R5", int'(full), int'(outst == MAX_OUT), "full flag");
      check("R4", int'(issueReady), int'((outst < MAX_OUT) && (!reqOcc || reqLeaves)), "issueReady");
      check("R7", int'(dataBusy), int'(expBusy), "dataBusy");
      if (expPv[3]) check("R12", int'(rspTag), int'(expRt), "rspTag");
      if (expPv[4]) check("R8 R12", int'(dataTag), int'(expDt), "dataTag");
      check("R9", int'(retireValid), int'(expRet), "retire pulse");
      if (expRet) check("R9", int'(retireTag), int'(expRetTag), "retire tag order");
      if (retireValid) begin
        if (R == 1 && L == 1 && !gap && retired == 0)
          check("R2", c - c0, 6, "first retire cycle without stalls");
        retired++;
      end
      accFlag = issueValid && issueReady;
      @(negedge clk);
    end
    issueValid = 0; rspDone = 0; dataLast = 0;
    check("R9", retired, NTX, "retirement count");
  endtask

  initial begin
    int gap10Full;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle state after reset
    check("R1", int'(phaseValid), 0, "phases after reset");
    check("R1", int'(full), 0, "full after reset");
    check("R1", int'(issueReady), 1, "issueReady after reset");
    check("R1", int'(retireValid), 0, "retire after reset");
    check("R1", int'(dataBusy), 0, "dataBusy after reset");
    // R11: done/last strobes with nothing to end
    rspDone = 1; dataLast = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R11", int'(phaseValid), 0, "phases with stray strobes");
      check("R11", int'(retireValid), 0, "retire with stray strobes");
      check("R11", int'(full), 0, "full with stray strobes");
    end
    rspDone = 0; dataLast = 0;
    gap10Full = 0;
    for (int r = 1; r <= 3; r++) begin
      for (int li = 0; li < 4; li++) begin
        for (int g = 0; g < 2; g++) begin
          int L;
          L = (li == 3) ? 10 : li + 1;
          runCase(r, L, g[0], r * 5 + li * 3 + g);
        end
      end
    end
    // R5: the ten-beat configuration must have reached the outstanding limit
    predict(0, 1, 10, 1'b0);
    for (int c = 0; c < 200; c++) begin
      int o;
      o = 0;
      for (int i = 0; i < NTX; i++) if (e0[i] <= c && dd[i] + 10 > c) o++;
      if (o == MAX_OUT) gap10Full = 1;
    end
    check("R5", gap10Full, 1, "limit reached by long data phases");
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  always @(posedge clk) begin
    if (!finished && cyc > WATCHDOG) begin
      nTests++;
      nFails++;
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end
endmodule